// File: doc/BRIEF.md
# Separate-Port Two-Beat Burst Memory

This block is an on-chip memory with one read data port and one write data port. The two ports share a single address bus. Every location holds a pair of words, and each access moves that pair as a burst of two beats. The design runs on a beat clock, where each beat stands for half of a double-rate cycle. Two beats make one access cycle. The first beat of a cycle is the read slot and the second is the write slot. The block drives `slot_o` so the surrounding logic knows which slot the next clock edge samples.

A read request is taken in the read slot. Its two words come back two cycles later, lower word first, with `rd_valid` high for both beats. A write request is taken in the write slot. Its lower word and byte enables follow in the next read slot, and its upper word and byte enables follow in the write slot after that. The whole pair is then held in a pending register. That register is written into the array only when the next write burst completes. A read that hits the pending address merges the enabled bytes of the pending data over the array contents, so it always sees the newest data.

Both ports can be busy in every cycle. This gives an unbroken stream of two-beat bursts on each port.

Top module: `split_port_burst_mem`

## Requirements
- R1: While `rst` is high, and afterwards until the first read burst returns, `rd_valid` is low. No write is pending after reset.
- R2: When `rd_en` is high at an edge with `slot_o`=0, the pair at `addr` comes back on the beats that follow the fourth and fifth edges after that edge, with `rd_valid` high on both. The lower word comes on the beat with `slot_o`=1, and the upper word comes on the next beat.
- R3: When `wr_en` is high at an edge with `slot_o`=1, `addr` is taken as the write address. `wr_data`/`wr_be` at the next edge give the lower word, and at the edge after that they give the upper word.
- R4: A port whose enable is low in its slot ignores `addr`, `wr_data` and `wr_be`. No read burst is produced and no location changes.
- R5: Bit i of `wr_be` enables bits [i*BYTE_W +: BYTE_W] of the word on that beat. Bytes whose enable is low keep their earlier value.
- R6: A read returns the result of every write whose address was taken in an earlier cycle. This includes a write that is still pending and not yet written into the array, merged byte by byte.
- R7: A write whose address is taken in the same cycle as a read (that is, in the following write slot) is not seen by that read. It is seen by reads in later cycles.
- R8: Read and write requests issued in every cycle give back-to-back read bursts with `rd_valid` held high, and each burst carries its correct data.
- R9: `slot_o` is 0 during reset and on the first edge after reset. It then toggles on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; two edges make one access cycle |
| rst | input | 1 | Synchronous active-high reset |
| slot_o | output | 1 | Slot that the next edge samples: 0 read, 1 write |
| addr | input | $clog2(DEPTH) | Shared address bus: read address in slot 0, write address in slot 1 |
| rd_en | input | 1 | Read request, sampled in the read slot |
| wr_en | input | 1 | Write request, sampled in the write slot |
| wr_data | input | WORD_W | Write data beat: lower word, then upper word |
| wr_be | input | WORD_W/BYTE_W | Byte enables of the current write beat |
| rd_data | output | WORD_W | Read data beat, registered |
| rd_valid | output | 1 | High on both beats of a returning read burst |

## Verification
The bench builds the block with its defaults: 256 locations, 18-bit words and 9-bit bytes. This gives two byte enables per beat and four byte lanes per pair. Byte-lane merging can then be tested in every mix of lower and upper lanes, and the top address 255 is reachable. The reference model applies each write one cycle after its address slot. With this model, forwarding from the pending register, same-cycle read-before-write ordering, and fully loaded back-to-back traffic are all checked on every beat.

// File: rtl/spbm_pkg.sv
`timescale 1ns/1ps
package spbm_pkg;
  // slot that the next clock edge samples on the shared address bus
  typedef enum logic {
    SLOT_RD = 1'b0,
    SLOT_WR = 1'b1
  } slot_e;
endpackage

// File: rtl/spbm_lane_ram.sv
`timescale 1ns/1ps
// One byte lane of the pair array: simple dual-port, synchronous read.
module spbm_lane_ram #(
  parameter int DEPTH  = 256,
  parameter int BYTE_W = 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spbm_write_path.sv
`timescale 1ns/1ps
// Write request capture, two-beat data capture and the pending pair register.
module spbm_write_path
  import spbm_pkg::*;
#(
  parameter int AW     = 8,
  parameter int WORD_W = 18,
  parameter int BPW    = 2,
  localparam int PAIR_W = 2 * WORD_W,
  localparam int LANES  = 2 * BPW
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_e             slot,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BPW-1:0]    wr_be,
  output logic              commit_en,
  output logic [AW-1:0]     commit_addr,
  output logic [PAIR_W-1:0] commit_data,
  output logic [LANES-1:0]  commit_be,
  output logic              pend_valid,
  output logic [AW-1:0]     pend_addr,
  output logic [PAIR_W-1:0] pend_data,
  output logic [LANES-1:0]  pend_be
);
  logic              req_v;
  logic [AW-1:0]     req_a;
  logic [WORD_W-1:0] lo_q;
  logic [BPW-1:0]    lo_be_q;
  logic              burst_done;

  // the upper beat of a requested burst lands on this write-slot edge
  assign burst_done = (slot == SLOT_WR) && req_v;

  // the older pending pair is written into the array when a newer one replaces it
  assign commit_en   = burst_done && pend_valid;
  assign commit_addr = pend_addr;
  assign commit_data = pend_data;
  assign commit_be   = pend_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_v      <= 1'b0;
      pend_valid <= 1'b0;
    end else begin
      if (slot == SLOT_WR) begin
        req_v <= wr_en;
        req_a <= addr;
      end else begin
        lo_q    <= wr_data;
        lo_be_q <= wr_be;
      end
      if (burst_done) begin
        pend_valid <= 1'b1;
        pend_addr  <= req_a;
        pend_data  <= {wr_data, lo_q};
        pend_be    <= {wr_be, lo_be_q};
      end
    end
  end
endmodule

// File: rtl/spbm_read_path.sv
`timescale 1ns/1ps
// Read request capture, array read, pending-write merge and beat serialisation.
module spbm_read_path
  import spbm_pkg::*;
#(
  parameter int AW     = 8,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9,
  localparam int BPW    = WORD_W / BYTE_W,
  localparam int PAIR_W = 2 * WORD_W,
  localparam int LANES  = 2 * BPW
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_e             slot,
  input  logic [AW-1:0]     addr,
  input  logic              rd_en,
  input  logic              pend_valid,
  input  logic [AW-1:0]     pend_addr,
  input  logic [PAIR_W-1:0] pend_data,
  input  logic [LANES-1:0]  pend_be,
  input  logic [PAIR_W-1:0] arr_rdata,
  output logic              arr_re,
  output logic [AW-1:0]     arr_raddr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              req_v;
  logic [AW-1:0]     req_a;
  logic              s2_v;
  logic              fwd_hit;
  logic [LANES-1:0]  fwd_be;
  logic [PAIR_W-1:0] fwd_data;
  logic [PAIR_W-1:0] merged;
  logic              m_v;
  logic [PAIR_W-1:0] m_pair;

  // array is read one cycle after the request, on a read-slot edge
  assign arr_re    = (slot == SLOT_RD);
  assign arr_raddr = req_a;

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*BYTE_W +: BYTE_W] = (fwd_hit && fwd_be[l])
                                        ? fwd_data[l*BYTE_W +: BYTE_W]
                                        : arr_rdata[l*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_v    <= 1'b0;
      s2_v     <= 1'b0;
      fwd_hit  <= 1'b0;
      m_v      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (slot == SLOT_RD) begin
      req_v    <= rd_en;
      req_a    <= addr;
      s2_v     <= req_v;
      // snapshot the newest write alongside the array read
      fwd_hit  <= pend_valid && (pend_addr == req_a);
      fwd_be   <= pend_be;
      fwd_data <= pend_data;
      rd_valid <= m_v;
      rd_data  <= m_v ? m_pair[WORD_W-1:0] : '0;
    end else begin
      m_v      <= s2_v;
      m_pair   <= merged;
      rd_valid <= m_v;
      rd_data  <= m_v ? m_pair[PAIR_W-1:WORD_W] : '0;
    end
  end
endmodule

// File: rtl/split_port_burst_mem.sv
`timescale 1ns/1ps
// Separate read/write data ports sharing one address bus; two-beat bursts.
module split_port_burst_mem
  import spbm_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9,
  localparam int AW     = $clog2(DEPTH),
  localparam int BPW    = WORD_W / BYTE_W,
  localparam int PAIR_W = 2 * WORD_W,
  localparam int LANES  = 2 * BPW
) (
  input  logic              clk,
  input  logic              rst,
  output logic              slot_o,
  input  logic [AW-1:0]     addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BPW-1:0]    wr_be,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  slot_e             slot;
  logic              commit_en;
  logic [AW-1:0]     commit_addr;
  logic [PAIR_W-1:0] commit_data;
  logic [LANES-1:0]  commit_be;
  logic              pend_valid;
  logic [AW-1:0]     pend_addr;
  logic [PAIR_W-1:0] pend_data;
  logic [LANES-1:0]  pend_be;
  logic              arr_re;
  logic [AW-1:0]     arr_raddr;
  logic [PAIR_W-1:0] arr_rdata;

  always_ff @(posedge clk) begin
    if (rst) slot <= SLOT_RD;
    else     slot <= (slot == SLOT_RD) ? SLOT_WR : SLOT_RD;
  end
  assign slot_o = slot;

  spbm_write_path #(
    .AW(AW), .WORD_W(WORD_W), .BPW(BPW)
  ) u_wr (
    .clk(clk), .rst(rst), .slot(slot), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
    .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_data(commit_data), .commit_be(commit_be),
    .pend_valid(pend_valid), .pend_addr(pend_addr),
    .pend_data(pend_data), .pend_be(pend_be)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    spbm_lane_ram #(
      .DEPTH(DEPTH), .BYTE_W(BYTE_W)
    ) u_ram (
      .clk(clk),
      .we(commit_en && commit_be[l]),
      .waddr(commit_addr),
      .wdata(commit_data[l*BYTE_W +: BYTE_W]),
      .re(arr_re),
      .raddr(arr_raddr),
      .rdata(arr_rdata[l*BYTE_W +: BYTE_W])
    );
  end

  spbm_read_path #(
    .AW(AW), .WORD_W(WORD_W), .BYTE_W(BYTE_W)
  ) u_rd (
    .clk(clk), .rst(rst), .slot(slot), .addr(addr), .rd_en(rd_en),
    .pend_valid(pend_valid), .pend_addr(pend_addr),
    .pend_data(pend_data), .pend_be(pend_be),
    .arr_rdata(arr_rdata), .arr_re(arr_re), .arr_raddr(arr_raddr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/spbm_checker.sv
`timescale 1ns/1ps
module spbm_checker (
  input logic clk,
  input logic rst,
  input logic slot_o,
  input logic rd_en,
  input logic rd_valid
);
  // R1: no read beat while in reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !rd_valid);

  // R9: slot alternates on every edge out of reset
  assert_slot_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (slot_o != $past(slot_o)));

  // R2: a lower-word beat is always followed by the upper-word beat
  assert_beat_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && slot_o) |=> (rd_valid && !slot_o));

  // R2: fixed latency from read request to first beat
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !slot_o) |-> ##5 (rd_valid && slot_o));

  // R4: a burst only ever answers a real read request
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && slot_o) |-> $past(rd_en && !slot_o, 5));
endmodule

bind split_port_burst_mem spbm_checker u_spbm_checker (
  .clk(clk), .rst(rst), .slot_o(slot_o), .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/split_port_burst_mem_bench.sv
`timescale 1ns/1ps
module split_port_burst_mem_bench;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         slot_o;
  logic [7:0]   addr = '0;
  logic         rd_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   wr_be = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid;

  split_port_burst_mem u_split_port_burst_mem (
    .clk(clk), .rst(rst), .slot_o(slot_o), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0;
  int n_fail = 0;
  int ecnt = 0;
  string cur_tag = "R2";

  logic [2*W-1:0] mem_m [int];
  logic [W-1:0]   exp_d [int];
  string          exp_t [int];

  // previous cycle's write, whose data beats go out in the current cycle
  bit         pw_v = 0;
  int         pw_a;
  logic [W-1:0] pw_lo, pw_hi;
  logic [1:0] pw_blo, pw_bhi;

  task automatic chk(input bit ok, input string req, input logic [W:0] act, input logic [W:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(posedge clk) if (!rst) ecnt++;

  // per-beat comparison against the model's schedule
  always @(negedge clk) begin
    if (rst) begin
      chk(rd_valid === 1'b0 && slot_o === 1'b0, "R1/R9 reset", {rd_valid, 17'd0, slot_o}, '0);
    end else if (ecnt > 0) begin
      int key;
      key = ecnt - 1;
      if (exp_d.exists(key)) begin
        chk(rd_valid === 1'b1 && rd_data === exp_d[key], exp_t[key],
            {rd_valid, rd_data}, {1'b1, exp_d[key]});
        exp_d.delete(key);
        exp_t.delete(key);
      end else begin
        chk(rd_valid === 1'b0, "R4/R1 no burst", {rd_valid, rd_data}, '0);
      end
    end
  end

  function automatic logic [2*W-1:0] merge(input logic [2*W-1:0] old, input logic [W-1:0] lo,
      input logic [1:0] blo, input logic [W-1:0] hi, input logic [1:0] bhi);
    logic [2*W-1:0] r;
    r = old;
    for (int i = 0; i < 2; i++) begin
      if (blo[i]) r[i*9 +: 9] = lo[i*9 +: 9];
      if (bhi[i]) r[W + i*9 +: 9] = hi[i*9 +: 9];
    end
    return r;
  endfunction

  // one access cycle; called right after a falling edge with slot_o == 0
  task automatic cyc(input bit rd, input int ra, input bit wr, input int wa,
      input logic [W-1:0] lo, input logic [1:0] blo, input logic [W-1:0] hi, input logic [1:0] bhi);
    chk(slot_o === 1'b0, "R9 slot", {18'd0, slot_o}, '0);
    if (pw_v) begin
      logic [2*W-1:0] base;
      base = mem_m.exists(pw_a) ? mem_m[pw_a] : '0;
      mem_m[pw_a] = merge(base, pw_lo, pw_blo, pw_hi, pw_bhi);
    end
    if (rd) begin
      exp_d[ecnt + 4] = mem_m[ra][W-1:0];
      exp_d[ecnt + 5] = mem_m[ra][2*W-1:W];
      exp_t[ecnt + 4] = cur_tag;
      exp_t[ecnt + 5] = cur_tag;
    end
    rd_en = rd; wr_en = 1'b0; addr = 8'(ra);
    wr_data = pw_v ? pw_lo : W'($urandom);
    wr_be   = pw_v ? pw_blo : 2'($urandom);
    @(negedge clk);
    rd_en = 1'b0; wr_en = wr; addr = 8'(wa);
    wr_data = pw_v ? pw_hi : W'($urandom);
    wr_be   = pw_v ? pw_bhi : 2'($urandom);
    @(negedge clk);
    wr_en = 1'b0;
    addr = 8'($urandom);
    pw_v = wr; pw_a = wa; pw_lo = lo; pw_blo = blo; pw_hi = hi; pw_bhi = bhi;
  endtask

  function automatic int pick();
    int i;
    i = $urandom_range(0, 8);
    return (i == 8) ? 255 : i;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R3: fill locations with full pairs, R2: read them back
    cur_tag = "R3 fill";
    for (int a = 0; a < 9; a++) begin
      int ad;
      ad = (a == 8) ? 255 : a;
      cyc(0, 0, 1, ad, W'(18'h1000 + ad), 2'b11, W'(18'h2000 + ad), 2'b11);
    end
    cyc(0, 0, 0, 0, '0, '0, '0, '0);
    cur_tag = "R2 readback";
    for (int a = 0; a < 9; a++) cyc(1, (a == 8) ? 255 : a, 0, 0, '0, '0, '0, '0);

    // R5: partial byte writes, read from pending then from array
    cur_tag = "R5 byte enables";
    cyc(0, 0, 1, 3, 18'h3ABCD, 2'b01, 18'h05A5A, 2'b10);
    cyc(0, 0, 0, 0, '0, '0, '0, '0);
    cyc(1, 3, 1, 4, 18'h11111, 2'b11, 18'h22222, 2'b00);
    cyc(1, 3, 0, 0, '0, '0, '0, '0);
    cyc(1, 4, 0, 0, '0, '0, '0, '0);

    // R6: read right behind a write; two stacked partial writes
    cur_tag = "R6 forwarding";
    cyc(0, 0, 1, 5, 18'h0F0F0, 2'b11, 18'h3C3C3, 2'b11);
    cyc(1, 5, 1, 6, 18'h15555, 2'b10, 18'h0AAAA, 2'b01);
    cyc(0, 0, 1, 6, 18'h2CCCC, 2'b01, 18'h13333, 2'b10);
    cyc(1, 6, 0, 0, '0, '0, '0, '0);
    cyc(1, 6, 0, 0, '0, '0, '0, '0);

    // R7: read and write to the same location in one cycle
    cur_tag = "R7 same cycle";
    cyc(1, 7, 1, 7, 18'h0BEEF, 2'b11, 18'h1CAFE, 2'b11);
    cyc(1, 7, 0, 0, '0, '0, '0, '0);

    // R4: idle ports with busy address and data lines
    cur_tag = "R4 idle";
    for (int i = 0; i < 4; i++) cyc(0, pick(), 0, pick(), W'($urandom), 2'b11, W'($urandom), 2'b11);
    for (int a = 0; a < 9; a++) cyc(1, (a == 8) ? 255 : a, 0, 0, '0, '0, '0, '0);

    // R8: both ports busy every cycle
    cur_tag = "R8 streaming";
    for (int i = 0; i < 60; i++)
      cyc(1, pick(), 1, pick(), W'($urandom), 2'($urandom), W'($urandom), 2'($urandom));
    cyc(1, pick(), 0, 0, '0, '0, '0, '0);
    for (int a = 0; a < 9; a++) cyc(1, (a == 8) ? 255 : a, 0, 0, '0, '0, '0, '0);

    repeat (8) @(negedge clk);
    chk(exp_d.size() == 0, "R2 all bursts seen", W'(exp_d.size()), '0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule